// File: doc/BRIEF.md
# Programmable-Distribution Amplitude Sampler

This block draws random pulse amplitudes whose histogram follows a distribution that software loads as a table of cumulative thresholds. On each accepted request, a 16-bit pseudo-random value is taken from a maximal-length shift-register generator. The block then searches the threshold table for the interval that holds the value. Many random values fall into the same interval, so the table turns a uniform source into samples of the stored distribution. The memory is never addressed by the random value itself.

The table sits in a synchronous-read block memory of 2^IDX_W words, and the word address is the amplitude. Word k holds the lowest random value that yields amplitude k. Word 0 is never read, because amplitude 0 covers every value below word 1. The search is a bit-serial binary search. It fixes one amplitude bit per clock, from the MSB down, and does one memory read per step. A request therefore completes in a fixed IDX_W steps. The table is loaded through a simple write port while the block is idle.

Top module: `amp_sampler`

## Requirements
- R1: During and after reset, `busy_o`, `amp_valid_o` and `amp_o` are all 0.
- R2: The random value used by the n-th accepted request (n = 0, 1, ...) is SEED advanced n times. Each step shifts the 16-bit state left by one and inserts, at bit 0, the XOR of bits 15, 13, 12 and 10 (polynomial x^16+x^14+x^13+x^11+1). The default SEED is 0xACE1. The state is never zero.
- R3: For random value r and an ascending table T, the result is the largest k in 1..2^IDX_W-1 with T[k] <= r, or 0 if there is none. Word 0 is ignored.
- R4: A value exactly equal to T[k] belongs to the upper interval and yields k, not k-1.
- R5: Values below T[1] give amplitude 0. Values at or above T[2^IDX_W-1] give the maximum amplitude 2^IDX_W-1.
- R6: When a request is sampled at rising edge n, `amp_valid_o` is high for exactly the one cycle after edge n+IDX_W, with the result on `amp_o`.
- R7: `busy_o` is high from the edge that accepts a request until the edge that raises `amp_valid_o`. A request seen while busy is ignored: it produces no result and does not advance the generator.
- R8: A table write is accepted only when the block is idle and no request is sampled in the same cycle. Writes during a search, or in the accepting cycle, are dropped.
- R9: `amp_o` holds the last result until the next `amp_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request one amplitude sample |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | IDX_W | Table word to write (equals amplitude index) |
| wr_data_i | input | RND_W | Threshold value for that word |
| busy_o | output | 1 | Search in progress |
| amp_valid_o | output | 1 | One-cycle strobe marking a new result |
| amp_o | output | IDX_W | Sampled amplitude |

## Verification
The hardest case to reach from the ports is a table write that arrives while a search is running or in the same cycle as the accepting request. It cannot change the result of that search. It can only corrupt the next one, and only if it hits the word that the next random value depends on. The bench keeps its own copy of the generator, so it knows the next random value in advance. It loads a table where the amplitude is the value's top byte, then writes, mid-search, the word that would drop the next result by one. A correct block returns the unchanged amplitude. A block that lets the write through returns one less. Equality and the two saturation ends are reached the same way, by building each table around the predicted value.

// File: rtl/amp_pkg.sv
package amp_pkg;

    // Search controller state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SRCH = 1'b1
    } srch_st_e;

    // Default sizing shared by the sampler and its checker
    localparam int unsigned DEF_RND_W = 16;
    localparam int unsigned DEF_IDX_W = 8;

endpackage

// File: rtl/amp_lfsr.sv
module amp_lfsr #(
    parameter int unsigned   W    = 16,
    parameter logic [W-1:0]  TAPS = 16'hB400,
    parameter logic [W-1:0]  SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    output logic [W-1:0] state_o
);

    logic [W-1:0] state_d;
    logic [W-1:0] state_q;
    logic         fb;

    always_comb begin
        fb      = ^(state_q & TAPS);
        state_d = state_q;
        if (state_q == '0) begin
            // lock-up guard: reload the seed
            state_d = SEED;
        end else if (step_i) begin
            state_d = {state_q[W-2:0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/amp_thresh_ram.sv
module amp_thresh_ram #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          re_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
        if (re_i) begin
            rdata_q <= mem_q[raddr_i];
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/amp_search_fsm.sv
module amp_search_fsm
    import amp_pkg::*;
#(
    parameter int unsigned RW = 16,
    parameter int unsigned IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [RW-1:0] rnd_i,
    input  logic [RW-1:0] rd_data_i,
    output logic          rd_en_o,
    output logic [IW-1:0] rd_addr_o,
    output logic          lfsr_step_o,
    output logic          wr_ok_o,
    output logic          busy_o,
    output logic          valid_o,
    output logic [IW-1:0] amp_o
);

    localparam logic [IW-1:0] TOP_BIT = {1'b1, {(IW-1){1'b0}}};

    typedef struct packed {
        srch_st_e      st;
        logic [RW-1:0] rnd;   // captured random value
        logic [IW-1:0] acc;   // amplitude bits fixed so far
        logic [IW-1:0] bitm;  // one-hot bit under test
        logic [IW-1:0] amp;   // last result
        logic          valid;
    } srch_t;

    srch_t         s_d;
    srch_t         s_q;
    logic          take;
    logic [IW-1:0] acc_nx;

    always_comb begin
        s_d         = s_q;
        s_d.valid   = 1'b0;
        rd_en_o     = 1'b0;
        rd_addr_o   = '0;
        lfsr_step_o = 1'b0;
        wr_ok_o     = 1'b0;

        // probed word is the lower bound of amplitude (acc | bitm)
        take   = (rd_data_i <= s_q.rnd);
        acc_nx = take ? (s_q.acc | s_q.bitm) : s_q.acc;

        unique case (s_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    s_d.st      = ST_SRCH;
                    s_d.rnd     = rnd_i;
                    s_d.acc     = '0;
                    s_d.bitm    = TOP_BIT;
                    rd_en_o     = 1'b1;
                    rd_addr_o   = TOP_BIT;
                    lfsr_step_o = 1'b1;
                end else begin
                    wr_ok_o = 1'b1;
                end
            end
            ST_SRCH: begin
                s_d.acc = acc_nx;
                if (s_q.bitm[0]) begin
                    s_d.st    = ST_IDLE;
                    s_d.amp   = acc_nx;
                    s_d.valid = 1'b1;
                    s_d.bitm  = '0;
                end else begin
                    s_d.bitm  = s_q.bitm >> 1;
                    rd_en_o   = 1'b1;
                    rd_addr_o = acc_nx | (s_q.bitm >> 1);
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o  = (s_q.st == ST_SRCH);
    assign valid_o = s_q.valid;
    assign amp_o   = s_q.amp;

endmodule

// File: rtl/amp_sampler.sv
module amp_sampler #(
    parameter int unsigned        RND_W = 16,
    parameter int unsigned        IDX_W = 8,
    parameter logic [RND_W-1:0]   TAPS  = 16'hB400,
    parameter logic [RND_W-1:0]   SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_addr_i,
    input  logic [RND_W-1:0] wr_data_i,
    output logic             busy_o,
    output logic             amp_valid_o,
    output logic [IDX_W-1:0] amp_o
);

    logic [RND_W-1:0] lfsr_w;
    logic             lfsr_step;
    logic             rd_en;
    logic [IDX_W-1:0] rd_addr;
    logic [RND_W-1:0] rd_data;
    logic             wr_ok;
    logic             ram_we;

    amp_lfsr #(
        .W    (RND_W),
        .TAPS (TAPS),
        .SEED (SEED)
    ) u_rng (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (lfsr_step),
        .state_o (lfsr_w)
    );

    // writes land only in idle cycles with no request
    assign ram_we = wr_en_i & wr_ok;

    amp_thresh_ram #(
        .AW (IDX_W),
        .DW (RND_W)
    ) u_tbl (
        .clk     (clk),
        .we_i    (ram_we),
        .waddr_i (wr_addr_i),
        .wdata_i (wr_data_i),
        .re_i    (rd_en),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

    amp_search_fsm #(
        .RW (RND_W),
        .IW (IDX_W)
    ) u_srch (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .rnd_i       (lfsr_w),
        .rd_data_i   (rd_data),
        .rd_en_o     (rd_en),
        .rd_addr_o   (rd_addr),
        .lfsr_step_o (lfsr_step),
        .wr_ok_o     (wr_ok),
        .busy_o      (busy_o),
        .valid_o     (amp_valid_o),
        .amp_o       (amp_o)
    );

endmodule

// File: rtl/amp_sampler_chk.sv
module amp_sampler_chk #(
    parameter int unsigned RW = 16,
    parameter int unsigned IW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_i,
    input logic          busy_o,
    input logic          amp_valid_o,
    input logic [IW-1:0] amp_o,
    input logic [RW-1:0] lfsr_w
);

    localparam int unsigned CW = $clog2(IW + 2) + 1;

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy_o) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    p_lfsr_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_w != '0);

    p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && !busy_o |=> busy_o);

    p_valid_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        amp_valid_o |-> !busy_o && $past(busy_o));

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        amp_valid_o |=> !amp_valid_o);

    p_fall_gives_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> amp_valid_o);

    p_search_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CW'(IW));

    p_amp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !amp_valid_o |-> $stable(amp_o));

endmodule

bind amp_sampler amp_sampler_chk #(
    .RW (RND_W),
    .IW (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .busy_o      (busy_o),
    .amp_valid_o (amp_valid_o),
    .amp_o       (amp_o),
    .lfsr_w      (lfsr_w)
);

// File: tb/sim_amp_sampler.sv
module sim_amp_sampler;

    localparam int          RW    = 16;
    localparam int          IW    = 8;
    localparam int          DEPTH = 1 << IW;
    localparam logic [15:0] TAPS  = 16'hB400;
    localparam logic [15:0] SEED  = 16'hACE1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_addr = '0;
    logic [RW-1:0] wr_data = '0;
    logic          busy;
    logic          valid;
    logic [IW-1:0] amp;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;
    logic [RW-1:0] tbl [DEPTH];
    logic [RW-1:0] mdl = SEED;

    amp_sampler #(.RND_W(RW), .IDX_W(IW), .TAPS(TAPS), .SEED(SEED)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .busy_o(busy), .amp_valid_o(valid), .amp_o(amp)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] next_lfsr(input logic [15:0] x);
        return {x[14:0], ^(x & TAPS)};
    endfunction

    // linear-scan model of R3
    function automatic int scan(input logic [15:0] r);
        int e = 0;
        for (int k = 1; k < DEPTH; k++) if (tbl[k] <= r) e = k;
        return e;
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic load_table();
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = IW'(k); wr_data = tbl[k];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // one request; optional injected request / write during the search
    task automatic sample(input string rq, input int inj_req_at, input int inj_wr_at,
                          input logic [IW-1:0] wa, input logic [RW-1:0] wd, output int got);
        bit tm_ok = 1'b1;
        int e;
        logic [15:0] r;
        @(negedge clk);
        req = 1'b1;
        if (inj_wr_at == 0) begin wr_en = 1'b1; wr_addr = wa; wr_data = wd; end
        @(posedge clk);
        @(negedge clk);
        req = 1'b0; wr_en = 1'b0;
        r = mdl; mdl = next_lfsr(mdl); e = scan(r);
        if (!busy || valid) tm_ok = 1'b0;
        for (int i = 1; i <= IW; i++) begin
            if (i == inj_req_at) req = 1'b1;
            if (i == inj_wr_at) begin wr_en = 1'b1; wr_addr = wa; wr_data = wd; end
            @(posedge clk);
            @(negedge clk);
            req = 1'b0; wr_en = 1'b0;
            if (i < IW && (!busy || valid)) tm_ok = 1'b0;
        end
        chk(tm_ok, "R7 busy during search", int'(busy), 1);
        chk(valid && !busy, "R6 valid after IW steps", int'(valid), 1);
        chk(amp == IW'(e), rq, int'(amp), e);
        got = int'(amp);
        @(negedge clk);
        chk(!valid, "R6 single-cycle valid", int'(valid), 0);
        chk(!busy, "R7 no restart from ignored request", int'(busy), 0);
    endtask

    task automatic t_reset();
        chk(!busy && !valid && amp == '0, "R1 reset state", int'({busy, valid}), 0);
        chk(amp == '0, "R1 reset amplitude", int'(amp), 0);
    endtask

    task automatic t_linear();
        int got;
        logic [15:0] r;
        for (int k = 0; k < DEPTH; k++) tbl[k] = 16'(k << 8);
        load_table();
        for (int n = 0; n < 6; n++) begin
            r = mdl;
            sample("R3 linear table", -1, -1, '0, '0, got);
            chk(got == int'(r[15:8]), "R2 generator sequence (top byte)", got, int'(r[15:8]));
        end
    endtask

    task automatic t_square();
        int got;
        for (int k = 0; k < DEPTH; k++) tbl[k] = 16'(k * k);
        load_table();
        for (int n = 0; n < 5; n++) sample("R3 quadratic table", -1, -1, '0, '0, got);
    endtask

    task automatic t_boundary();
        int got;
        if (mdl == 16'hFFFF) begin
            for (int k = 0; k < DEPTH; k++) tbl[k] = 16'(k << 8);
            load_table();
            sample("R3 filler", -1, -1, '0, '0, got);
        end
        for (int k = 0; k < DEPTH; k++) tbl[k] = (k < 77) ? 16'h0000 : 16'hFFFF;
        tbl[77] = mdl;
        load_table();
        sample("R4 equal to threshold", -1, -1, '0, '0, got);
        chk(got == 77, "R4 equality goes to upper interval", got, 77);
    endtask

    task automatic t_extremes();
        int got;
        if (mdl == 16'hFFFF) begin
            sample("R3 filler", -1, -1, '0, '0, got);
        end
        for (int k = 0; k < DEPTH; k++) tbl[k] = 16'hFFFF;
        load_table();
        sample("R5 below first threshold", -1, -1, '0, '0, got);
        chk(got == 0, "R5 amplitude zero", got, 0);
        for (int k = 0; k < DEPTH; k++) tbl[k] = 16'h0001;
        load_table();
        sample("R5 above last threshold", -1, -1, '0, '0, got);
        chk(got == DEPTH - 1, "R5 maximum amplitude", got, DEPTH - 1);
    endtask

    task automatic t_busy_req();
        int got;
        for (int k = 0; k < DEPTH; k++) tbl[k] = 16'(k << 8);
        load_table();
        sample("R7 request injected mid-search", 4, -1, '0, '0, got);
        sample("R7 request injected at last step", IW, -1, '0, '0, got);
        sample("R7 generator not advanced by ignored requests", -1, -1, '0, '0, got);
    endtask

    // pick the word the next value depends on and try to disturb it
    task automatic t_busy_wr_one(input int at, input string rq);
        int got;
        int m;
        logic [15:0] rb;
        rb = next_lfsr(mdl);
        m = int'(rb[15:8]);
        while (m < 1 || m > DEPTH - 2) begin
            sample("R3 filler", -1, -1, '0, '0, got);
            rb = next_lfsr(mdl);
            m = int'(rb[15:8]);
        end
        sample(rq, -1, at, IW'(m), rb + 16'd1, got);
        sample(rq, -1, -1, '0, '0, got);
        chk(got == m, rq, got, m);
    endtask

    task automatic t_busy_wr();
        int got;
        int m;
        logic [15:0] r;
        for (int k = 0; k < DEPTH; k++) tbl[k] = 16'(k << 8);
        load_table();
        t_busy_wr_one(2, "R8 write during search dropped");
        t_busy_wr_one(0, "R8 write with accepted request dropped");
        r = mdl;
        m = int'(r[15:8]);
        if (m >= 1) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = IW'(m); wr_data = r + 16'd1;
            tbl[m] = r + 16'd1;
            @(negedge clk);
            wr_en = 1'b0;
            sample("R8 idle write accepted", -1, -1, '0, '0, got);
            chk(got == m - 1, "R8 idle write takes effect", got, m - 1);
        end
    endtask

    task automatic t_hold();
        int got;
        sample("R3 before hold", -1, -1, '0, '0, got);
        repeat (5) @(negedge clk);
        chk(int'(amp) == got && !valid, "R9 amplitude held", int'(amp), got);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_linear();
        t_square();
        t_boundary();
        t_extremes();
        t_busy_req();
        t_busy_wr();
        t_hold();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule